// File: doc/BRIEF.md
# Configuration and Status Register Bank

This block is a register bank that sits between a simple register bus and a core. The bus side has an address, a write enable, write data and read data. Read data is registered, so it appears one clock after the address. The bank holds two kinds of register.

The first kind is a pass-through register. A bus write to its address hands the data to the core, together with a one-cycle strobe. A bus read of that address returns a value that the core drives continuously.

The second kind is a field-based register whose fields are stored inside the bank. Every field carries two access policies: one for the bus and one for the core. Each policy is one of read-only, write-only or read-write. When the fields together are wider than a bus word, the register spans several consecutive addresses. The most significant word sits at the lowest of these addresses.

The widths, addresses, reset values and policies are all parameters. The defaults are:
- an 8-bit bus and a 4-bit address;
- a 6-bit pass-through register at address 0;
- four fields of widths 5, 7, 4 and 6, packed from bit 0 upward. They form a 22-bit register over three words at addresses 2, 3 and 4.

Top module: `csr_field_bank`

## Requirements
- R1: While `rst_n` is low, `bus_rdata` is zero, `raw_wr_stb` is low and every field holds its reset value. The default reset values are field0=0x11, field1=0x00, field2=0x3 and field3=0x2A.
- R2: `bus_rdata` changes only at a rising clock edge. After that edge it shows the word at the address that was present at the edge.
- R3: A bus write to the pass-through address raises `raw_wr_stb` for exactly the one cycle after the write edge. In that cycle `raw_wr_data` carries the low RAW_W bits of the written word. No strobe occurs without such a write.
- R4: A read of the pass-through address returns `raw_rd_value` as sampled at the read edge, zero-extended to the bus width.
- R5: The field register is packed with field 0 at bit 0 and each later field directly above the previous one, then padded with zeros to a whole number of words. Address WIDE_BASE+k holds word k counted from the most significant end. With the defaults:
   - address 2 holds field3 in bits 5:0;
   - address 3 holds field2 in bits 7:4 and field1[6:3] in bits 3:0;
   - address 4 holds field1[2:0] in bits 7:5 and field0 in bits 4:0.
- R6: A bus write updates only the field bits inside the addressed word, and only for fields whose bus policy allows writing. Bus writes to fields that are read-only on the bus are ignored. Bus reads of fields that are write-only on the bus, and of pad bits, return zero. The default bus policies are field0 RW, field1 RW, field2 RO and field3 WO.
- R7: `fld_q` shows each field's stored value at its packed position when the core policy allows reading, and zero otherwise. The default core policies are field0 RO, field1 RW, field2 WO and field3 RO.
- R8: When bit i of `fld_we` is high and field i is core-writable, the field loads its slice of `fld_d` at that edge. For fields that are not core-writable, the strobe is ignored.
- R9: When the core and the bus write the same field at the same edge, the whole field takes the core value. Other fields in the addressed word still take the bus data.
- R10: Reads of unmapped addresses return zero. Writes to unmapped addresses change no field and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write enable for the addressed word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| raw_wr_data | output | RAW_W | Pass-through write data, valid with the strobe |
| raw_wr_stb | output | 1 | One-cycle pass-through write strobe |
| raw_rd_value | input | RAW_W | Core-supplied pass-through read value |
| fld_q | output | TOT_W | Core view of the packed fields |
| fld_d | input | TOT_W | Core write values, packed like the fields |
| fld_we | input | NF | Per-field core write strobes |

## Verification
The hardest situation to reach is a same-edge collision. In it, the core rewrites a field while a bus write covers part of that same field and also another field in the word. To produce it, the bench first moves the fields away from their reset values through a walked table of bus accesses. It then drives a core strobe and a bus write in one cycle. Finally it reads back both words that the split field spans, so the outcome is visible on both sides of the word boundary. Partial-word writes across a field that straddles two addresses are reached the same way: writes to one word are followed by a read of the other word.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

   typedef enum logic [1:0] {
      ACC_RO = 2'd0,
      ACC_WO = 2'd1,
      ACC_RW = 2'd2
   } acc_e;

   function automatic bit acc_can_read(acc_e a);
      return (a == ACC_RO) || (a == ACC_RW);
   endfunction

   function automatic bit acc_can_write(acc_e a);
      return (a == ACC_WO) || (a == ACC_RW);
   endfunction

endpackage

// File: rtl/csr_field_cell.sv
module csr_field_cell import csr_bank_pkg::*; #(
   parameter int unsigned W       = 1,
   parameter acc_e        BUS_POL = ACC_RW,
   parameter acc_e        DEV_POL = ACC_RW,
   parameter logic [W-1:0] RST    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] bus_be,
   input  logic [W-1:0] bus_d,
   input  logic         core_we,
   input  logic [W-1:0] core_d,
   output logic [W-1:0] bus_q,
   output logic [W-1:0] core_q
);

   localparam bit BUS_WR = acc_can_write(BUS_POL);
   localparam bit BUS_RD = acc_can_read(BUS_POL);
   localparam bit DEV_WR = acc_can_write(DEV_POL);
   localparam bit DEV_RD = acc_can_read(DEV_POL);
   localparam logic [W-1:0] BUS_MASK = BUS_WR ? '1 : '0;

   logic [W-1:0] store;
   logic [W-1:0] bus_en;

   assign bus_en = bus_be & BUS_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store <= RST;
      end else if (DEV_WR && core_we) begin
         store <= core_d;
      end else begin
         store <= (store & ~bus_en) | (bus_d & bus_en);
      end
   end

   assign bus_q  = BUS_RD ? store : '0;
   assign core_q = DEV_RD ? store : '0;

   generate
      if (DEV_WR) begin : g_a_dev
         assert_core_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
            core_we |=> store == $past(core_d));
         if (BUS_WR) begin : g_a_both
            assert_core_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
               (core_we && (|bus_be)) |=> store == $past(core_d));
         end
      end
      if (!BUS_WR) begin : g_a_busro
         assert_bus_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(DEV_WR && core_we) |=> $stable(store));
      end
   endgenerate

endmodule

// File: rtl/csr_raw_port.sv
module csr_raw_port #(
   parameter int unsigned RAW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic [RAW_W-1:0] wdata,
   output logic             stb,
   output logic [RAW_W-1:0] data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb  <= 1'b0;
         data <= '0;
      end else begin
         stb <= wr_hit;
         if (wr_hit) begin
            data <= wdata;
         end
      end
   end

endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned RAW_W     = 8,
   parameter int unsigned RAW_ADDR  = 0,
   parameter int unsigned WIDE_BASE = 1,
   parameter int unsigned NW        = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [RAW_W-1:0]     raw_value,
   input  logic [NW*DATA_W-1:0] wide_view,
   output logic [DATA_W-1:0]    rdata
);

   logic [DATA_W-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      if (addr == ADDR_W'(RAW_ADDR)) begin
         rd_next = DATA_W'(raw_value);
      end
      for (int k = 0; k < NW; k++) begin
         if (addr == ADDR_W'(WIDE_BASE + k)) begin
            rd_next = wide_view[(NW-1-k)*DATA_W +: DATA_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else begin
         rdata <= rd_next;
      end
   end

endmodule

// File: rtl/csr_field_bank.sv
module csr_field_bank import csr_bank_pkg::*; #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned RAW_W     = 6,
   parameter int unsigned RAW_ADDR  = 0,
   parameter int unsigned WIDE_BASE = 2,
   parameter int unsigned NF        = 4,
   parameter int unsigned FLD_W   [NF] = '{5, 7, 4, 6},
   parameter logic [31:0] FLD_RST [NF] = '{32'h11, 32'h00, 32'h3, 32'h2A},
   parameter acc_e        BUS_POL [NF] = '{ACC_RW, ACC_RW, ACC_RO, ACC_WO},
   parameter acc_e        DEV_POL [NF] = '{ACC_RO, ACC_RW, ACC_WO, ACC_RO},
   localparam int unsigned TOT_W = fld_offset(NF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [RAW_W-1:0]  raw_wr_data,
   output logic              raw_wr_stb,
   input  logic [RAW_W-1:0]  raw_rd_value,
   output logic [TOT_W-1:0]  fld_q,
   input  logic [TOT_W-1:0]  fld_d,
   input  logic [NF-1:0]     fld_we
);

   function automatic int unsigned fld_offset(int unsigned idx);
      int unsigned s = 0;
      for (int i = 0; i < NF; i++) begin
         if (i < idx) s += FLD_W[i];
      end
      return s;
   endfunction

   localparam int unsigned NW    = (TOT_W + DATA_W - 1) / DATA_W;
   localparam int unsigned PAD_W = NW * DATA_W;

   // elaboration-time parameter checks
   generate
      if (RAW_W < 1 || RAW_W > DATA_W) begin : g_chk_raw
         $error("pass-through width must be 1..DATA_W");
      end
      if (WIDE_BASE + NW > (1 << ADDR_W)) begin : g_chk_space
         $error("field register does not fit the address space");
      end
      if (RAW_ADDR >= WIDE_BASE && RAW_ADDR < WIDE_BASE + NW) begin : g_chk_overlap
         $error("pass-through address overlaps the field register");
      end
      for (genvar c = 0; c < NF; c++) begin : g_chk_fld
         if (FLD_W[c] < 1 || FLD_W[c] > 32) begin : g_bad
            $error("field width must be 1..32");
         end
      end
   endgenerate

   logic              raw_hit;
   logic [NW-1:0]     word_hit;
   logic [PAD_W-1:0]  bus_bit_we;
   logic [PAD_W-1:0]  bus_wvec;
   logic [PAD_W-1:0]  bus_view;
   logic              rd_mapped;

   assign raw_hit = (bus_addr == ADDR_W'(RAW_ADDR));

   generate
      for (genvar k = 0; k < NW; k++) begin : g_word
         localparam int unsigned LSB = (NW - 1 - k) * DATA_W;
         assign word_hit[k] = (bus_addr == ADDR_W'(WIDE_BASE + k));
         assign bus_bit_we[LSB +: DATA_W] = {DATA_W{bus_we && word_hit[k]}};
         assign bus_wvec[LSB +: DATA_W]   = bus_wdata;
      end

      if (PAD_W > TOT_W) begin : g_pad
         assign bus_view[PAD_W-1:TOT_W] = '0;
      end

      for (genvar g = 0; g < NF; g++) begin : g_fld
         localparam int unsigned OFF = fld_offset(g);
         localparam int unsigned W   = FLD_W[g];
         csr_field_cell #(
            .W       (W),
            .BUS_POL (BUS_POL[g]),
            .DEV_POL (DEV_POL[g]),
            .RST     (FLD_RST[g][W-1:0])
         ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .bus_be  (bus_bit_we[OFF +: W]),
            .bus_d   (bus_wvec[OFF +: W]),
            .core_we (fld_we[g]),
            .core_d  (fld_d[OFF +: W]),
            .bus_q   (bus_view[OFF +: W]),
            .core_q  (fld_q[OFF +: W])
         );
      end
   endgenerate

   csr_raw_port #(
      .RAW_W (RAW_W)
   ) u_raw (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (bus_we && raw_hit),
      .wdata  (bus_wdata[RAW_W-1:0]),
      .stb    (raw_wr_stb),
      .data   (raw_wr_data)
   );

   csr_read_mux #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .RAW_W     (RAW_W),
      .RAW_ADDR  (RAW_ADDR),
      .WIDE_BASE (WIDE_BASE),
      .NW        (NW)
   ) u_rmux (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (bus_addr),
      .raw_value (raw_rd_value),
      .wide_view (bus_view),
      .rdata     (bus_rdata)
   );

   assign rd_mapped = raw_hit || (|word_hit);

   assert_raw_strobe_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      raw_wr_stb |-> $past(bus_we && bus_addr == ADDR_W'(RAW_ADDR)));

   assert_raw_strobe_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && raw_hit) |=> (raw_wr_stb && raw_wr_data == $past(bus_wdata[RAW_W-1:0])));

   assert_raw_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      raw_hit |=> bus_rdata == DATA_W'($past(raw_rd_value)));

   assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_mapped |=> bus_rdata == '0);

endmodule

// File: tb/test_csr_field_bank.sv
module test_csr_field_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [5:0]  raw_wr_data;
   logic        raw_wr_stb;
   logic [5:0]  raw_rd_value = 6'h2D;
   logic [21:0] fld_q;
   logic [21:0] fld_d = '0;
   logic [3:0]  fld_we = '0;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 0;

   always #4 clk = ~clk;

   csr_field_bank i_csr_field_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (bus_addr),
      .bus_we       (bus_we),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .raw_wr_data  (raw_wr_data),
      .raw_wr_stb   (raw_wr_stb),
      .raw_rd_value (raw_rd_value),
      .fld_q        (fld_q),
      .fld_d        (fld_d),
      .fld_we       (fld_we)
   );

   // {addr[3:0], we, wdata[7:0], expected rdata[7:0]}
   localparam int NV = 16;
   localparam logic [20:0] VEC [NV] = '{
      {4'd0, 1'b0, 8'h00, 8'h2D},  // R4 pass-through read
      {4'd1, 1'b0, 8'h00, 8'h00},  // R10 unmapped read
      {4'd3, 1'b0, 8'h00, 8'h30},  // R5 reset layout, middle word
      {4'd4, 1'b0, 8'h00, 8'h11},  // R5 reset layout, low word
      {4'd2, 1'b0, 8'h00, 8'h00},  // R6 bus write-only field reads zero
      {4'd4, 1'b1, 8'hFF, 8'h11},  // R2 old value returned on write
      {4'd4, 1'b0, 8'h00, 8'hFF},  // R5 low word written
      {4'd3, 1'b1, 8'hFF, 8'h30},  // R6 field2 bus-RO part ignored
      {4'd3, 1'b0, 8'h00, 8'h3F},  // R6 only field1 bits changed
      {4'd2, 1'b1, 8'h15, 8'h00},  // R6 write to bus-WO field3
      {4'd2, 1'b0, 8'h00, 8'h00},  // R6 still reads zero
      {4'd5, 1'b1, 8'hAA, 8'h00},  // R10 unmapped write
      {4'd3, 1'b0, 8'h00, 8'h3F},  // R10 nothing changed
      {4'd4, 1'b1, 8'h00, 8'hFF},  // R5 clear low word
      {4'd4, 1'b0, 8'h00, 8'h00},  // R5 low word cleared
      {4'd3, 1'b0, 8'h00, 8'h3F}   // R5 upper part of field1 kept
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cycle(input logic [3:0] a, input logic we, input logic [7:0] wd,
                        input logic [3:0] fwe, input logic [21:0] fd);
      @(negedge clk);
      bus_addr  = a;
      bus_we    = we;
      bus_wdata = wd;
      fld_we    = fwe;
      fld_d     = fd;
      @(posedge clk);
      #1;
   endtask

   task automatic bus_op(input logic [3:0] a, input logic we, input logic [7:0] wd);
      cycle(a, we, wd, 4'b0000, 22'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 8);
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 rdata in reset", 32'(bus_rdata), 32'h0);
      check("R1 strobe in reset", 32'(raw_wr_stb), 32'h0);
      check("R1 R7 field reset values", 32'(fld_q), 32'h2A0011);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         bus_op(VEC[i][20:17], VEC[i][16], VEC[i][15:8]);
         check($sformatf("R5 R6 R10 vector %0d", i), 32'(bus_rdata), 32'(VEC[i][7:0]));
         check($sformatf("R10 no strobe vector %0d", i), 32'(raw_wr_stb), 32'h0);
      end
      bus_op(4'd1, 1'b0, 8'h00);
      check("R7 core view after bus writes", 32'(fld_q), 32'h150F00);

      // R3 pass-through write
      bus_op(4'd0, 1'b1, 8'hFA);
      check("R3 strobe after write", 32'(raw_wr_stb), 32'h1);
      check("R3 data low bits", 32'(raw_wr_data), 32'h3A);
      bus_op(4'd0, 1'b0, 8'h00);
      check("R3 strobe one cycle", 32'(raw_wr_stb), 32'h0);
      check("R4 read core value", 32'(bus_rdata), 32'h2D);
      @(negedge clk);
      raw_rd_value = 6'h11;
      bus_op(4'd0, 1'b0, 8'h00);
      check("R4 read tracks core value", 32'(bus_rdata), 32'h11);

      // R2 latency: address change alone does not move rdata
      @(negedge clk);
      bus_addr = 4'd3;
      #1;
      check("R2 rdata held before edge", 32'(bus_rdata), 32'h11);
      @(posedge clk);
      #1;
      check("R2 rdata after edge", 32'(bus_rdata), 32'h3F);

      // R8 core write to core-writable field2
      cycle(4'd1, 1'b0, 8'h00, 4'b0100, 22'h009000);
      bus_op(4'd3, 1'b0, 8'h00);
      check("R8 core write field2 seen on bus", 32'(bus_rdata), 32'h9F);
      check("R7 core-WO field hidden from core", 32'(fld_q), 32'h150F00);

      // R8 core strobe on core-RO field0 ignored
      cycle(4'd1, 1'b0, 8'h00, 4'b0001, 22'h000005);
      bus_op(4'd4, 1'b0, 8'h00);
      check("R8 core-RO field0 unchanged on bus", 32'(bus_rdata), 32'h00);
      check("R8 core-RO field0 unchanged at core", 32'(fld_q), 32'h150F00);

      // R9 collision on field1, bus also writes field0
      cycle(4'd4, 1'b1, 8'hE3, 4'b0010, 22'h000240);
      bus_op(4'd4, 1'b0, 8'h00);
      check("R9 low word after collision", 32'(bus_rdata), 32'h43);
      bus_op(4'd3, 1'b0, 8'h00);
      check("R9 middle word after collision", 32'(bus_rdata), 32'h92);
      check("R9 core view after collision", 32'(fld_q), 32'h150243);

      // R1 reset in mid run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 rdata cleared by reset", 32'(bus_rdata), 32'h0);
      check("R1 fields restored by reset", 32'(fld_q), 32'h2A0011);
      @(negedge clk);
      rst_n = 1'b1;
      bus_op(4'd3, 1'b0, 8'h00);
      check("R1 field2 restored on bus", 32'(bus_rdata), 32'h30);

      finish_run();
   end

endmodule